// File: doc/BRIEF.md
# Discrete First-Order Lag Plant

This block models a first-order lag, a gain K over a single time constant T, in hardware so that a controller under test can close a loop around it. It is clocked by a fixed system clock and advances the plant state on a slower sample tick. The tick is produced internally by dividing the clock by a fixed oversampling factor. With the defaults the clock is 100 MHz, the divider is 100 and the sample period is 1 us.

Software writes three run-time values through a simple write port: the plant input u, the gain K, and 1/T. The time constant is written as its reciprocal so that the update needs only multiplications and no divider. A one-shot clear request zeroes the integrator state once, after which integration carries on. The state is held at twice the port width, so that the tiny per-sample increments of a slow plant are not rounded away. The output y is the state rounded back to port width, and a one-cycle valid pulse marks each new value.

Top module: `lag_plant`

## Requirements
- R1: With the state update running, y_valid pulses for one cycle once every CLK_DIV (default 100) clock cycles. The first pulse comes 104 clock edges after reset is released: the tick is at edge 100, followed by four pipeline edges.
- R2: On each tick, x becomes x + step. Here step = floor((K*u - x) * rcp * TS_Q / 2^56), and TS_Q = 1099512 is the sample period 1 us scaled by 2^40. u, K and rcp (which is 1/T) are signed Q16.16. The state x is signed Q32.32.
- R3: A write with wr_en=1 loads wr_data into the register chosen by wr_sel. The codes are 0 for u, 1 for K and 2 for rcp. Code 3 changes no register.
- R4: Each update uses the register values held just before the tick edge. A write that lands on the tick edge itself takes effect only from the following tick.
- R5: A pulse on clr_state is held pending until the next state update. That update sets x to 0 instead of integrating, and later ticks integrate normally from zero.
- R6: K*u - x, the step and the new state each saturate to the signed 64-bit range rather than wrapping.
- R7: y is x rounded to Q16.16 with halves rounded away from zero, and saturated to the signed 32-bit range. A non-negative x never gives a negative y, and a negative x never gives a positive y.
- R8: A synchronous active-high rst clears the state, the tick counter, the pending clear, the three registers, y and y_valid.
- R9: y changes only in the cycle where y_valid is high, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 input, 1 gain, 2 reciprocal time constant, 3 none |
| wr_data | input | IO_W | Write value, signed Q16.16 |
| clr_state | input | 1 | One-shot integrator clear request |
| y | output | IO_W | Plant output, signed Q16.16 |
| y_valid | output | 1 | One-cycle pulse marking a new output |

## Verification
The assertions check several properties on every cycle. They check the spacing of the output pulses at exactly one divider period, and that each pulse lasts a single cycle. They check that y holds still between pulses, that y takes the sign of the internal state, and that y and y_valid are cleared by reset. The numeric value of each update can only be shown by the bench's sample-by-sample reference model. The same holds for when register writes take effect relative to the tick, for the deferred clear and for saturation under a diverging plant, since these depend on sequences of writes and ticks.

// File: rtl/lag_plant_pkg.sv
package lag_plant_pkg;

  // register select codes on the write port
  typedef enum logic [1:0] {
    SEL_INPUT = 2'd0,
    SEL_GAIN  = 2'd1,
    SEL_RCP   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // number of register stages between the tick and the output
  localparam int unsigned PIPE_STAGES = 4;

endpackage

// File: rtl/lag_tick_gen.sv
module lag_tick_gen #(
  parameter int unsigned CLK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/lag_param_regs.sv
module lag_param_regs
  import lag_plant_pkg::*;
#(
  parameter int unsigned IO_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [IO_W-1:0] wr_data,
  output logic [IO_W-1:0] u_q,
  output logic [IO_W-1:0] k_q,
  output logic [IO_W-1:0] rcp_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      u_q   <= '0;
      k_q   <= '0;
      rcp_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_INPUT: u_q   <= wr_data;
        SEL_GAIN:  k_q   <= wr_data;
        SEL_RCP:   rcp_q <= wr_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/lag_update.sv
module lag_update #(
  parameter int unsigned IO_W    = 32,
  parameter int unsigned IO_FRAC = 16,
  parameter int unsigned TS_FRAC = 40,
  parameter int unsigned TS_Q    = 1099512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [IO_W-1:0]   u,
  input  logic [IO_W-1:0]   k,
  input  logic [IO_W-1:0]   rcp,
  input  logic              clr,
  output logic [2*IO_W-1:0] state,
  output logic              upd_done
);
  localparam int unsigned ST_W   = 2 * IO_W;
  localparam int unsigned TS_W   = $clog2(TS_Q + 1) + 1;
  localparam int unsigned COEF_W = IO_W + TS_W;
  localparam int unsigned DW     = ST_W + COEF_W;
  localparam int unsigned SH     = IO_FRAC + TS_FRAC;
  localparam logic signed [COEF_W-1:0] TS_C = COEF_W'(TS_Q);
  localparam logic [ST_W-1:0] ST_MAX = {1'b0, {(ST_W-1){1'b1}}};
  localparam logic [ST_W-1:0] ST_MIN = {1'b1, {(ST_W-1){1'b0}}};

  // stage flags: tick -> diff -> step -> state -> done
  logic [2:0] stg_q;

  logic signed [ST_W-1:0]   prod_q, diff_q, step_q, x_q;
  logic signed [COEF_W-1:0] coef_q;
  logic                     pend_q;
  logic                     done_q;

  // stage 1 operands (params sampled at the tick edge)
  logic signed [ST_W-1:0]   k_ext, u_ext, prod_c;
  logic signed [COEF_W-1:0] rcp_ext, coef_c;

  assign k_ext   = {{IO_W{k[IO_W-1]}}, k};
  assign u_ext   = {{IO_W{u[IO_W-1]}}, u};
  assign prod_c  = k_ext * u_ext;
  assign rcp_ext = {{TS_W{rcp[IO_W-1]}}, rcp};
  assign coef_c  = rcp_ext * TS_C;

  // stage 2: saturated difference
  logic [ST_W:0]   diff_w;
  logic [ST_W-1:0] diff_c;

  assign diff_w = {prod_q[ST_W-1], prod_q} - {x_q[ST_W-1], x_q};
  assign diff_c = (diff_w[ST_W] != diff_w[ST_W-1]) ?
                  (diff_w[ST_W] ? ST_MIN : ST_MAX) : diff_w[ST_W-1:0];

  // stage 3: scaled step, saturated to the state range
  logic signed [DW-1:0] diff_ext, coef_ext, wide, shifted;
  logic [DW-ST_W:0]     hi_bits;
  logic                 step_ovf;
  logic [ST_W-1:0]      step_c;

  assign diff_ext = {{COEF_W{diff_q[ST_W-1]}}, diff_q};
  assign coef_ext = {{ST_W{coef_q[COEF_W-1]}}, coef_q};
  assign wide     = diff_ext * coef_ext;
  assign shifted  = wide >>> SH;
  assign hi_bits  = shifted[DW-1:ST_W-1];
  assign step_ovf = !((&hi_bits) || !(|hi_bits));
  assign step_c   = step_ovf ? (shifted[DW-1] ? ST_MIN : ST_MAX)
                             : shifted[ST_W-1:0];

  // stage 4: saturated accumulate
  logic [ST_W:0]   sum_w;
  logic [ST_W-1:0] x_c;

  assign sum_w = {x_q[ST_W-1], x_q} + {step_q[ST_W-1], step_q};
  assign x_c   = (sum_w[ST_W] != sum_w[ST_W-1]) ?
                 (sum_w[ST_W] ? ST_MIN : ST_MAX) : sum_w[ST_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= '0;
      prod_q <= '0;
      coef_q <= '0;
      diff_q <= '0;
      step_q <= '0;
      x_q    <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      stg_q  <= {stg_q[1:0], tick};
      done_q <= stg_q[2];
      if (tick) begin
        prod_q <= prod_c;
        coef_q <= coef_c;
      end
      if (stg_q[0]) diff_q <= diff_c;
      if (stg_q[1]) step_q <= step_c;
      if (stg_q[2]) begin
        x_q    <= (pend_q || clr) ? '0 : x_c;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_q || clr;
      end
    end
  end

  assign state    = x_q;
  assign upd_done = done_q;
endmodule

// File: rtl/lag_out_round.sv
module lag_out_round #(
  parameter int unsigned IO_W    = 32,
  parameter int unsigned IO_FRAC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [2*IO_W-1:0] state,
  output logic [IO_W-1:0]   y,
  output logic              y_valid
);
  localparam int unsigned ST_W = 2 * IO_W;
  localparam int unsigned D    = IO_FRAC;  // fraction bits dropped
  localparam logic [ST_W:0] HALF    = {{(ST_W+1-D){1'b0}}, 1'b1, {(D-1){1'b0}}};
  localparam logic [ST_W:0] POS_LIM = {{(ST_W-IO_W+2){1'b0}}, {(IO_W-1){1'b1}}};
  localparam logic [ST_W:0] NEG_LIM = {{(ST_W-IO_W+1){1'b0}}, 1'b1, {(IO_W-1){1'b0}}};
  localparam logic [IO_W-1:0] Y_MAX = {1'b0, {(IO_W-1){1'b1}}};
  localparam logic [IO_W-1:0] Y_MIN = {1'b1, {(IO_W-1){1'b0}}};

  logic            neg;
  logic [ST_W:0]   ext, mag, rnd, q;
  logic [IO_W-1:0] y_c;

  assign neg = state[ST_W-1];
  assign ext = {state[ST_W-1], state};
  assign mag = neg ? ((ST_W+1)'(0) - ext) : ext;
  assign rnd = mag + HALF;
  assign q   = rnd >> D;

  always_comb begin
    if (!neg && (q > POS_LIM)) begin
      y_c = Y_MAX;
    end else if (neg && (q > NEG_LIM)) begin
      y_c = Y_MIN;
    end else if (neg) begin
      y_c = IO_W'(0) - q[IO_W-1:0];
    end else begin
      y_c = q[IO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y       <= '0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= load;
      if (load) y <= y_c;
    end
  end
endmodule

// File: rtl/lag_plant.sv
module lag_plant
  import lag_plant_pkg::*;
#(
  parameter int unsigned IO_W    = 32,
  parameter int unsigned IO_FRAC = 16,
  parameter int unsigned CLK_DIV = 100,
  parameter int unsigned TS_FRAC = 40,
  parameter int unsigned TS_Q    = 1099512
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [IO_W-1:0] wr_data,
  input  logic            clr_state,
  output logic [IO_W-1:0] y,
  output logic            y_valid
);
  localparam int unsigned ST_W = 2 * IO_W;

  logic            tick;
  logic [IO_W-1:0] u_q, k_q, rcp_q;
  logic [ST_W-1:0] state_w;
  logic            upd_done;

  lag_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  lag_param_regs #(.IO_W(IO_W)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .u_q    (u_q),
    .k_q    (k_q),
    .rcp_q  (rcp_q)
  );

  lag_update #(
    .IO_W   (IO_W),
    .IO_FRAC(IO_FRAC),
    .TS_FRAC(TS_FRAC),
    .TS_Q   (TS_Q)
  ) upd_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .u       (u_q),
    .k       (k_q),
    .rcp     (rcp_q),
    .clr     (clr_state),
    .state   (state_w),
    .upd_done(upd_done)
  );

  lag_out_round #(.IO_W(IO_W), .IO_FRAC(IO_FRAC)) out_i (
    .clk    (clk),
    .rst    (rst),
    .load   (upd_done),
    .state  (state_w),
    .y      (y),
    .y_valid(y_valid)
  );
endmodule

// File: rtl/lag_plant_chk.sv
module lag_plant_chk #(
  parameter int unsigned IO_W    = 32,
  parameter int unsigned CLK_DIV = 100
) (
  input logic              clk,
  input logic              rst,
  input logic [IO_W-1:0]   y,
  input logic              y_valid,
  input logic [2*IO_W-1:0] state
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (y_valid) begin
      gap_q  <= 32'd1;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 32'd1;
    end
  end

  // R1
  tick_period_chk: assert property (@(posedge clk) disable iff (rst)
    (y_valid && seen_q) |-> (gap_q == CLK_DIV));

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ((y == '0) && !y_valid));

  // R7
  sign_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (state[2*IO_W-1] ? (y[IO_W-1] || (y == '0)) : !y[IO_W-1]));
endmodule

bind lag_plant lag_plant_chk #(.IO_W(IO_W), .CLK_DIV(CLK_DIV)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .y      (y),
  .y_valid(y_valid),
  .state  (state_w)
);

// File: tb/lag_plant_tb.sv
module lag_plant_tb_top;
  localparam int DIV  = 100;
  localparam longint TSQ = 1099512;
  localparam logic signed [127:0] MAX64 = 128'sd9223372036854775807;
  localparam logic signed [127:0] MIN64 = -MAX64 - 128'sd1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        clr_state = 1'b0;
  logic [31:0] y;
  logic        y_valid;

  int checks = 0;
  int errors = 0;
  string cur_req = "R8";

  always #5 clk = ~clk;

  lag_plant dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_state(clr_state), .y(y), .y_valid(y_valid)
  );

  // ---------------- reference model ----------------
  function automatic logic signed [63:0] sat64(input logic signed [127:0] v);
    if (v > MAX64) return MAX64[63:0];
    if (v < MIN64) return MIN64[63:0];
    return v[63:0];
  endfunction

  function automatic logic signed [63:0] next_x(input logic signed [63:0] x,
      input logic signed [31:0] uu, input logic signed [31:0] kk,
      input logic signed [31:0] rr);
    logic signed [127:0] p, d, s;
    p = 128'(kk) * 128'(uu);
    d = 128'(sat64(p - 128'(x)));
    s = (d * 128'(rr) * 128'(TSQ)) >>> 56;
    return sat64(128'(x) + 128'(sat64(s)));
  endfunction

  function automatic logic [31:0] round_y(input logic signed [63:0] x);
    logic signed [127:0] m, r;
    m = (x < 0) ? -128'(x) : 128'(x);
    m = (m + 128'sd32768) >>> 16;
    r = (x < 0) ? -m : m;
    if (r > 128'sd2147483647) return 32'h7FFF_FFFF;
    if (r < -128'sd2147483648) return 32'h8000_0000;
    return r[31:0];
  endfunction

  logic signed [63:0] m_x;
  logic signed [31:0] m_u, m_k, m_r, s_u, s_k, s_r;
  logic [31:0]        m_y;
  bit                 m_valid, m_pend, started;
  int                 m_cnt, m_ph;

  initial begin
    m_x = 0; m_u = 0; m_k = 0; m_r = 0; s_u = 0; s_k = 0; s_r = 0;
    m_y = 0; m_valid = 0; m_pend = 0; started = 0; m_cnt = 0; m_ph = 0;
  end

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_x = 0; m_u = 0; m_k = 0; m_r = 0; m_y = 0;
      m_valid = 0; m_pend = 0; m_cnt = 0; m_ph = 0;
    end else begin
      m_valid = 0;
      if (m_ph == 4) begin
        m_y = round_y(m_x);
        m_valid = 1;
      end
      if (m_ph == 3) begin
        m_x = (m_pend || clr_state) ? 64'sd0 : next_x(m_x, s_u, s_k, s_r);
        m_pend = 0;
      end else begin
        m_pend = m_pend || clr_state;
      end
      if (m_cnt == DIV - 1) begin
        s_u = m_u; s_k = m_k; s_r = m_r;
        m_ph = 1;
      end else if (m_ph > 0 && m_ph < 4) begin
        m_ph = m_ph + 1;
      end else begin
        m_ph = 0;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_u = wr_data;
          2'd1: m_k = wr_data;
          2'd2: m_r = wr_data;
          default: ;
        endcase
      end
      m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (y_valid !== m_valid) begin
        errors++;
        $display("FAIL %s/R1: y_valid=%0b expected %0b at %0t", cur_req, y_valid, m_valid, $time);
      end
      checks++;
      if (y !== m_y) begin
        errors++;
        $display("FAIL %s/R2: y=%h expected %h at %0t", cur_req, y, m_y, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!y_valid);
  endtask

  task automatic pulse_clear();
    clr_state = 1'b1;
    @(negedge clk);
    clr_state = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (4) @(negedge clk);
    cur_req = "R8";
    check("R8 reset y", y, 32'h0);
    check("R8 reset valid", {31'd0, y_valid}, 32'h0);
    rst = 1'b0;

    // R1 R2: positive step response, K=2.0 u=1.0 rcp=20000
    cur_req = "R2";
    write_reg(2'd1, 32'h0002_0000);
    write_reg(2'd0, 32'h0001_0000);
    write_reg(2'd2, 32'h4E20_0000);
    run_ticks(50);

    // R2: negative input, fractional gain and rcp
    write_reg(2'd0, 32'hFFFC_C000);
    write_reg(2'd1, 32'h0000_C000);
    write_reg(2'd2, 32'h04D2_8000);
    run_ticks(40);

    // R3: select code 3 writes nothing
    cur_req = "R3";
    write_reg(2'd3, 32'hDEAD_BEEF);
    run_ticks(5);

    // R4: write landing on the tick edge applies one tick later
    cur_req = "R4";
    while (m_cnt != DIV - 1) @(negedge clk);
    write_reg(2'd0, 32'h0005_0000);
    run_ticks(5);

    // R5: deferred clear gives a zero output, then integration resumes
    cur_req = "R5";
    pulse_clear();
    wait_valid();
    check("R5 cleared y", y, 32'h0);
    run_ticks(3);

    // R6 R7: diverging plant saturates state and output
    cur_req = "R6";
    pulse_clear();
    write_reg(2'd1, 32'h0001_0000);
    write_reg(2'd0, 32'h0064_0000);
    write_reg(2'd2, 32'h8000_0000);
    run_ticks(650);
    check("R6 R7 saturated y", y, 32'h8000_0000);

    // R8: mid-run reset clears registers and state
    cur_req = "R8";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 mid reset y", y, 32'h0);
    rst = 1'b0;
    run_ticks(3);
    check("R8 params cleared y", y, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule